// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

After a master reset, this block fills the four almost-full and almost-empty threshold registers of a bidirectional dual-FIFO. The registers are the full offset of port A, the empty offset of port B, the full offset of port C and the empty offset of port A. The loading order is fixed. A mode input is captured when reset ends and selects one of two loading methods:

- **Serial:** one bit per port-A clock from a serial data pin, taken only on cycles where the serial enable is high.
- **Parallel:** one whole offset per qualified port-A write cycle, taken from the low bits of the port-A data bus.

The block owns the input-ready flags of port A and port C. Both flags stay low while loading is in progress. Ordinary FIFO writes are suppressed until the last offset has landed. The port-C flag is carried into the port-C clock domain by a flop synchronizer. The four loaded offsets are driven out to the flag comparators, which sit outside this block.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: While master reset is low, both ready flags are low, all four offsets read zero and the FIFO write strobe is low.
- R2: The mode input is captured on the first port-A clock edge after reset release (1 = serial, 0 = parallel). Later changes to it have no effect until the next reset.
- R3: In serial mode, bits arrive most significant bit first. After 4·W enabled bits (W = log2 of depth), the offsets hold, in arrival order: full-A = bits 1..W, empty-B = the next W, full-C = the next W, empty-A = the last W.
- R4: In serial mode, a clock with the serial enable low neither advances the bit position nor changes any offset.
- R5: In parallel mode, a write counts only when wen=1, cs_n=0, wr_rd=1 and mbx=0. Each counted write stores data[W-1:0] into the next offset in the order full-A, empty-B, full-C, empty-A. A write missing any one qualifier changes nothing.
- R6: The port-A ready flag rises on the edge that takes the final bit or word, and stays high until the next reset.
- R7: While the port-A ready flag is low, the FIFO write strobe stays low even for a qualified write. Once the flag is high, the strobe equals the write qualification.
- R8: Once the port-A ready flag is high, further serial bits and writes leave all offsets unchanged.
- R9: The port-C ready flag follows the port-A flag through a two-flop synchronizer clocked by the port-C clock. It is never high while the port-A flag is low.
- R10: The method that was not chosen has no effect: serial enables are ignored in parallel mode, and qualified writes are ignored in serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port-A clock |
| clk_c | input | 1 | Port-C clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| ser_mode_i | input | 1 | Loading method select: 1 serial, 0 parallel |
| ser_en_i | input | 1 | Serial bit enable |
| ser_data_i | input | 1 | Serial offset data |
| a_cs_n_i | input | 1 | Port-A chip select, active low |
| a_wr_rd_i | input | 1 | Port-A direction, 1 = write |
| a_mbx_i | input | 1 | Port-A mailbox select, must be 0 for offsets |
| a_wen_i | input | 1 | Port-A write enable |
| a_data_i | input | DATA_W | Port-A data bus |
| fifo_wr_o | output | 1 | Qualified FIFO write, passed on only once ready |
| ready_a_o | output | 1 | Port-A input-ready flag |
| ready_c_o | output | 1 | Port-C input-ready flag, port-C clock domain |
| thr_full_a_o | output | W | Port-A almost-full offset |
| thr_empty_b_o | output | W | Port-B almost-empty offset |
| thr_full_c_o | output | W | Port-C almost-full offset |
| thr_empty_a_o | output | W | Port-A almost-empty offset |

## Verification
The assertions check, on every cycle:
- the ready flag never drops once set, and its rise is caused by an accepted bit or word;
- the FIFO strobe is never active without the flag;
- idle serial cycles and unqualified writes leave the offsets untouched, and the offsets are frozen after loading;
- the port-C flag never leads the port-A flag.

Only the bench scenarios can show:
- that the stored values sit in the right registers and the right bit order;
- that the mode capture ignores later changes to the mode input;
- that an enable stream with gaps still loads correctly;
- the two-clock delay of the port-C flag.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

   localparam int unsigned NUM_OFS = 4;

   typedef enum logic {
      PROG_PAR = 1'b0,
      PROG_SER = 1'b1
   } prog_mode_e;

   // Slot order is the loading order; the sequencer depends on it.
   typedef enum logic [1:0] {
      SLOT_FULL_A  = 2'd0,
      SLOT_EMPTY_B = 2'd1,
      SLOT_FULL_C  = 2'd2,
      SLOT_EMPTY_A = 2'd3
   } ofs_slot_e;

   function automatic logic wr_qualified(logic wen, logic cs_n, logic wr_rd, logic mbx);
      return wen & ~cs_n & wr_rd & ~mbx;
   endfunction

endpackage

// File: rtl/ofs_prog_seq.sv
module ofs_prog_seq
   import ofs_prog_pkg::*;
#(
   parameter int unsigned OFS_W = 6
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       mode_sel_i,
   input  logic       ser_en_i,
   input  logic       wr_qual_i,
   output prog_mode_e mode_o,
   output logic       shift_o,
   output logic       load_o,
   output logic [1:0] slot_o,
   output logic       done_o
);
   localparam int unsigned BITS  = NUM_OFS * OFS_W;
   localparam int unsigned CNT_W = $clog2(BITS + 1);
   localparam logic [CNT_W-1:0] SER_LAST = CNT_W'(BITS - 1);
   localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(NUM_OFS - 1);

   logic             capture_q;
   prog_mode_e       mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             step;
   logic [CNT_W-1:0] last;

   // Set during reset, cleared by the first edge after release.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) capture_q <= 1'b1;
      else         capture_q <= 1'b0;
   end

   // The mode is loaded on that same first edge and then held.
   always_ff @(posedge clk_i) begin
      if (capture_q) mode_q <= mode_sel_i ? PROG_SER : PROG_PAR;
   end

   assign last = (mode_q == PROG_SER) ? SER_LAST : PAR_LAST;
   assign step = ~capture_q & ~done_q &
                 ((mode_q == PROG_SER) ? ser_en_i : wr_qual_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == last) done_q <= 1'b1;
      end
   end

   assign mode_o  = mode_q;
   assign shift_o = step & (mode_q == PROG_SER);
   assign load_o  = step & (mode_q == PROG_PAR);
   assign slot_o  = cnt_q[1:0];
   assign done_o  = done_q;
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
   import ofs_prog_pkg::*;
#(
   parameter int unsigned OFS_W  = 6,
   parameter int unsigned DATA_W = 36
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             shift_i,
   input  logic                             sdata_i,
   input  logic                             load_i,
   input  logic [1:0]                       slot_i,
   input  logic [DATA_W-1:0]                pdata_i,
   output logic [NUM_OFS-1:0][OFS_W-1:0]    ofs_o
);
   logic [NUM_OFS-1:0][OFS_W-1:0] ofs_q;

   // Serial bits enter at the last slot and move toward slot 0, so the
   // first bits received end up in slot 0.
   for (genvar k = 0; k < NUM_OFS; k++) begin : g_slot
      logic carry_in;
      if (k == NUM_OFS - 1) begin : g_tail
         assign carry_in = sdata_i;
      end else begin : g_link
         assign carry_in = ofs_q[k+1][OFS_W-1];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ofs_q[k] <= '0;
         end else if (shift_i) begin
            ofs_q[k] <= {ofs_q[k][OFS_W-2:0], carry_in};
         end else if (load_i && (slot_i == 2'(k))) begin
            ofs_q[k] <= pdata_i[OFS_W-1:0];
         end
      end
   end

   assign ofs_o = ofs_q;
endmodule

// File: rtl/ofs_flag_sync.sv
module ofs_flag_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q[s] <= 1'b0;
         else         chain_q[s] <= (s == 0) ? d_i : chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ofs_prog_ctrl.sv
module ofs_prog_ctrl
   import ofs_prog_pkg::*;
#(
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned DATA_W      = 36,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned OFS_W      = $clog2(DEPTH)
) (
   input  logic              clk_a,
   input  logic              clk_c,
   input  logic              mrst_n,
   input  logic              ser_mode_i,
   input  logic              ser_en_i,
   input  logic              ser_data_i,
   input  logic              a_cs_n_i,
   input  logic              a_wr_rd_i,
   input  logic              a_mbx_i,
   input  logic              a_wen_i,
   input  logic [DATA_W-1:0] a_data_i,
   output logic              fifo_wr_o,
   output logic              ready_a_o,
   output logic              ready_c_o,
   output logic [OFS_W-1:0]  thr_full_a_o,
   output logic [OFS_W-1:0]  thr_empty_b_o,
   output logic [OFS_W-1:0]  thr_full_c_o,
   output logic [OFS_W-1:0]  thr_empty_a_o
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (DATA_W < OFS_W) begin : g_bad_width
      $error("DATA_W must cover the offset width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   prog_mode_e                    ser_mode_q;
   logic                          wr_qual;
   logic                          shift;
   logic                          load;
   logic [1:0]                    slot;
   logic                          done;
   logic [NUM_OFS-1:0][OFS_W-1:0] ofs;
   logic [NUM_OFS*OFS_W-1:0]      ofs_flat;

   assign wr_qual = wr_qualified(a_wen_i, a_cs_n_i, a_wr_rd_i, a_mbx_i);

   ofs_prog_seq #(.OFS_W(OFS_W)) u_seq (
      .clk_i      (clk_a),
      .rst_ni     (mrst_n),
      .mode_sel_i (ser_mode_i),
      .ser_en_i   (ser_en_i),
      .wr_qual_i  (wr_qual),
      .mode_o     (ser_mode_q),
      .shift_o    (shift),
      .load_o     (load),
      .slot_o     (slot),
      .done_o     (done)
   );

   ofs_bank #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_bank (
      .clk_i   (clk_a),
      .rst_ni  (mrst_n),
      .shift_i (shift),
      .sdata_i (ser_data_i),
      .load_i  (load),
      .slot_i  (slot),
      .pdata_i (a_data_i),
      .ofs_o   (ofs)
   );

   ofs_flag_sync #(.STAGES(SYNC_STAGES)) u_sync_c (
      .clk_i  (clk_c),
      .rst_ni (mrst_n),
      .d_i    (done),
      .q_o    (ready_c_o)
   );

   assign ofs_flat      = ofs;
   assign ready_a_o     = done;
   assign fifo_wr_o     = wr_qual & done;
   assign thr_full_a_o  = ofs[SLOT_FULL_A];
   assign thr_empty_b_o = ofs[SLOT_EMPTY_B];
   assign thr_full_c_o  = ofs[SLOT_FULL_C];
   assign thr_empty_a_o = ofs[SLOT_EMPTY_A];
endmodule

// File: rtl/ofs_prog_ctrl_chk.sv
module ofs_prog_ctrl_chk
   import ofs_prog_pkg::*;
#(
   parameter int unsigned OFS_W = 6
) (
   input logic                     clk_a,
   input logic                     clk_c,
   input logic                     mrst_n,
   input prog_mode_e               ser_mode_q,
   input logic                     ser_en_i,
   input logic                     a_cs_n_i,
   input logic                     a_wr_rd_i,
   input logic                     a_mbx_i,
   input logic                     a_wen_i,
   input logic                     fifo_wr_o,
   input logic                     ready_a_o,
   input logic                     ready_c_o,
   input logic [NUM_OFS*OFS_W-1:0] ofs_flat
);
   logic qual;
   assign qual = a_wen_i & ~a_cs_n_i & a_wr_rd_i & ~a_mbx_i;

   assert_ready_hold_R6: assert property (@(posedge clk_a) disable iff (!mrst_n)
      ready_a_o |=> ready_a_o);

   assert_ready_cause_R6: assert property (@(posedge clk_a) disable iff (!mrst_n)
      $rose(ready_a_o) |-> $past((ser_mode_q == PROG_SER) ? ser_en_i : qual));

   assert_wr_gated_R7: assert property (@(posedge clk_a) disable iff (!mrst_n)
      fifo_wr_o |-> ready_a_o);

   assert_frozen_R8: assert property (@(posedge clk_a) disable iff (!mrst_n)
      ready_a_o |=> $stable(ofs_flat));

   assert_gap_hold_R4: assert property (@(posedge clk_a) disable iff (!mrst_n)
      (ser_mode_q == PROG_SER && !ser_en_i) |=> $stable(ofs_flat));

   assert_par_ignore_R5: assert property (@(posedge clk_a) disable iff (!mrst_n)
      (ser_mode_q == PROG_PAR && !qual) |=> $stable(ofs_flat));

   assert_c_follows_R9: assert property (@(posedge clk_c) disable iff (!mrst_n)
      ready_c_o |-> ready_a_o);
endmodule

bind ofs_prog_ctrl ofs_prog_ctrl_chk #(.OFS_W(OFS_W)) u_chk (
   .clk_a      (clk_a),
   .clk_c      (clk_c),
   .mrst_n     (mrst_n),
   .ser_mode_q (ser_mode_q),
   .ser_en_i   (ser_en_i),
   .a_cs_n_i   (a_cs_n_i),
   .a_wr_rd_i  (a_wr_rd_i),
   .a_mbx_i    (a_mbx_i),
   .a_wen_i    (a_wen_i),
   .fifo_wr_o  (fifo_wr_o),
   .ready_a_o  (ready_a_o),
   .ready_c_o  (ready_c_o),
   .ofs_flat   (ofs_flat)
);

// File: tb/sim_ofs_prog_ctrl.sv
module sim_ofs_prog_ctrl;
   localparam int unsigned DEPTH  = 16;
   localparam int unsigned W      = 4;
   localparam int unsigned DATA_W = 8;

   logic              clk_a = 1'b0;
   logic              clk_c = 1'b0;
   logic              mrst_n = 1'b0;
   logic              ser_mode_i = 1'b0;
   logic              ser_en_i = 1'b0;
   logic              ser_data_i = 1'b0;
   logic              a_cs_n_i = 1'b1;
   logic              a_wr_rd_i = 1'b0;
   logic              a_mbx_i = 1'b0;
   logic              a_wen_i = 1'b0;
   logic [DATA_W-1:0] a_data_i = '0;
   logic              fifo_wr_o, ready_a_o, ready_c_o;
   logic [W-1:0]      thr_full_a_o, thr_empty_b_o, thr_full_c_o, thr_empty_a_o;

   int checks = 0;
   int errors = 0;

   always #10 clk_a = ~clk_a;   // 50 MHz
   always #13 clk_c = ~clk_c;

   ofs_prog_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SYNC_STAGES(2)) u0 (
      .clk_a, .clk_c, .mrst_n, .ser_mode_i, .ser_en_i, .ser_data_i,
      .a_cs_n_i, .a_wr_rd_i, .a_mbx_i, .a_wen_i, .a_data_i,
      .fifo_wr_o, .ready_a_o, .ready_c_o,
      .thr_full_a_o, .thr_empty_b_o, .thr_full_c_o, .thr_empty_a_o
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ofs_at(input int k);
      case (k)
         0: return int'(thr_full_a_o);
         1: return int'(thr_empty_b_o);
         2: return int'(thr_full_c_o);
         default: return int'(thr_empty_a_o);
      endcase
   endfunction

   function automatic int all_ofs();
      return (ofs_at(0) << 12) | (ofs_at(1) << 8) | (ofs_at(2) << 4) | ofs_at(3);
   endfunction

   task automatic cyc();
      @(negedge clk_a);
   endtask

   task automatic idle();
      ser_en_i = 1'b0; a_wen_i = 1'b0; a_cs_n_i = 1'b1;
      a_wr_rd_i = 1'b0; a_mbx_i = 1'b0;
   endtask

   task automatic good_wr(input int d);
      a_wen_i = 1'b1; a_cs_n_i = 1'b0; a_wr_rd_i = 1'b1; a_mbx_i = 1'b0;
      a_data_i = DATA_W'(d);
   endtask

   task automatic do_reset(input bit ser);
      idle();
      mrst_n = 1'b0;
      ser_mode_i = ser;
      repeat (3) cyc();
      chk(!ready_a_o && !ready_c_o, "R1", "ready flags in reset",
          int'({ready_a_o, ready_c_o}), 0);
      chk(all_ofs() == 0, "R1", "offsets in reset", all_ofs(), 0);
      good_wr(8'hA5);
      #1;
      chk(!fifo_wr_o, "R1", "write strobe in reset", int'(fifo_wr_o), 0);
      idle();
      mrst_n = 1'b1;
      cyc();              // mode capture edge
      ser_mode_i = ~ser;  // R2: must not matter any more
   endtask

   task automatic serial_round(input int v);
      int vals[4];
      int bit_b;
      int snap;
      vals[0] = v; vals[1] = v ^ 5; vals[2] = 15 - v; vals[3] = (v * 3) & 15;
      do_reset(1'b1);
      for (int idx = 0; idx < 4 * W; idx++) begin
         bit_b = (vals[idx / W] >> (W - 1 - (idx % W))) & 1;
         for (int g = 0; g < (v + idx) % 3; g++) begin
            snap = all_ofs();
            ser_en_i = 1'b0;
            ser_data_i = ~bit_b[0];
            if (idx % 5 == 0) good_wr(8'hFF);
            #1;
            chk(!fifo_wr_o, "R7", "strobe before ready", int'(fifo_wr_o), 0);
            cyc();
            idle();
            chk(all_ofs() == snap, "R4 R10", "offsets across gap", all_ofs(), snap);
         end
         if (idx == 4 * W - 1)
            chk(!ready_a_o, "R6", "ready before last bit", int'(ready_a_o), 0);
         ser_en_i = 1'b1;
         ser_data_i = bit_b[0];
         cyc();
         ser_en_i = 1'b0;
      end
      chk(ready_a_o, "R6", "ready after last bit", int'(ready_a_o), 1);
      chk(!ready_c_o, "R9", "port-C flag still low", int'(ready_c_o), 0);
      for (int k = 0; k < 4; k++)
         chk(ofs_at(k) == vals[k], "R2 R3", "serial offset", ofs_at(k), vals[k]);
      snap = all_ofs();
      good_wr(8'h3C);
      #1;
      chk(fifo_wr_o, "R7", "strobe after ready", int'(fifo_wr_o), 1);
      ser_en_i = 1'b1;
      ser_data_i = 1'b1;
      repeat (3) cyc();
      idle();
      chk(all_ofs() == snap, "R8", "offsets frozen", all_ofs(), snap);
      chk(ready_a_o, "R6", "ready held", int'(ready_a_o), 1);
      repeat (3) @(posedge clk_c);
      #1;
      chk(ready_c_o, "R9", "port-C flag raised", int'(ready_c_o), 1);
   endtask

   task automatic parallel_round(input int v);
      int vals[4];
      int snap;
      vals[0] = (v * 7) & 15; vals[1] = v; vals[2] = (v + 9) & 15; vals[3] = 15 - v;
      do_reset(1'b0);
      for (int k = 0; k < 4; k++) begin
         // four near-miss writes, each missing one qualifier, plus a serial bit
         for (int m = 0; m < 5; m++) begin
            snap = all_ofs();
            good_wr(8'hF0 | ((k + m) & 15));
            case (m)
               0: a_cs_n_i = 1'b1;
               1: a_wr_rd_i = 1'b0;
               2: a_mbx_i = 1'b1;
               3: a_wen_i = 1'b0;
               default: begin a_wen_i = 1'b0; ser_en_i = 1'b1; ser_data_i = 1'b1; end
            endcase
            cyc();
            idle();
            chk(all_ofs() == snap, (m == 4) ? "R10" : "R5", "ignored write",
                all_ofs(), snap);
         end
         if (k == 3)
            chk(!ready_a_o, "R6", "ready before last word", int'(ready_a_o), 0);
         good_wr(8'hA0 | vals[k]);
         #1;
         chk(!fifo_wr_o, "R7", "strobe during loading", int'(fifo_wr_o), 0);
         cyc();
         idle();
         chk(ofs_at(k) == vals[k], "R2 R5", "parallel offset", ofs_at(k), vals[k]);
      end
      chk(ready_a_o, "R6", "ready after last word", int'(ready_a_o), 1);
      snap = all_ofs();
      good_wr(8'h11);
      #1;
      chk(fifo_wr_o, "R7", "strobe after ready", int'(fifo_wr_o), 1);
      repeat (2) cyc();
      idle();
      chk(all_ofs() == snap, "R8", "offsets frozen", all_ofs(), snap);
      repeat (3) @(posedge clk_c);
      #1;
      chk(ready_c_o, "R9", "port-C flag raised", int'(ready_c_o), 1);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc();
      for (int v = 0; v < 16; v++) serial_round(v);
      for (int v = 0; v < 16; v++) parallel_round(v);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule